// File: doc/BRIEF.md
# Age-Ordered Reservation Station

An eight-slot issue queue placed in front of one execution unit. Each cycle it can take in one decoded micro-op: a destination tag, two source tags and a ready flag for each source. The queue watches two tag buses. The result bus says a value now exists. The early bus says a value will appear one cycle later. Every cycle the queue hands at most one waiting micro-op to its unit. The same block is copied once per unit class: integer, address generation, floating point and branch.

A micro-op may leave when each of its sources is either present or announced on the early bus. Such a micro-op can be sent ahead of its data, and the data arrives as execution begins. When several micro-ops qualify, the one allocated first leaves first. Its slot number plays no part in the choice. A flush input discards every queued micro-op in one cycle.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue holds nothing: `empty` is 1, `full` is 0 and `issueValid` is 0. `empty` is 1 exactly when no slot is occupied, and `full` is 1 exactly when all eight slots are occupied.
- R2: When `allocValid` is 1 and the queue is not full, the micro-op is written into a free slot at the clock edge. When the queue is full, the request is dropped with no effect: `full` stays 1, and a ready micro-op offered then never issues.
- R3: A queued micro-op is eligible when each of its two sources is either ready or marked ready-next-cycle. `issueValid` is 1 whenever some entry is eligible and no flush is active. A micro-op allocated with both ready flags set is offered on the issue outputs in the cycle after allocation.
- R4: At most one micro-op issues per cycle. Its destination and source tags appear on `issueDst`, `issueSrc0` and `issueSrc1` in the same cycle that `issueValid` is 1. Its slot is freed at that clock edge.
- R5: Among the eligible entries, the one allocated earliest issues first, whatever slots the entries occupy.
- R6: A tag on the result bus (`wakeValid` = 1) in cycle t marks every matching source of every queued entry ready from cycle t+1 on.
- R7: A tag on the early bus (`earlyValid` = 1) in cycle t marks matching sources ready-next-cycle. The entry can issue in cycle t+1, before the result itself is broadcast. A tag that does not match leaves the entry ineligible.
- R8: When an allocation's source tag equals a tag on the result bus or on the early bus in the same cycle, the new entry has that source marked ready or ready-next-cycle.
- R9: `flush` empties the queue at the next clock edge and drops any allocation made in the same cycle. Later wakeups then issue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard every queued micro-op |
| allocValid | input | 1 | New micro-op offered this cycle |
| allocDst | input | TAG_W | Destination tag of new micro-op |
| allocSrc0 | input | TAG_W | First source tag |
| allocSrc0Rdy | input | 1 | First source already available |
| allocSrc1 | input | TAG_W | Second source tag |
| allocSrc1Rdy | input | 1 | Second source already available |
| wakeValid | input | 1 | Result tag broadcast valid |
| wakeTag | input | TAG_W | Tag whose result now exists |
| earlyValid | input | 1 | Early tag broadcast valid |
| earlyTag | input | TAG_W | Tag whose result arrives next cycle |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| issueValid | output | 1 | A micro-op issues this cycle |
| issueDst | output | TAG_W | Destination tag of issuing micro-op |
| issueSrc0 | output | TAG_W | First source tag of issuing micro-op |
| issueSrc1 | output | TAG_W | Second source tag of issuing micro-op |

## Verification
Allocation, wakeups and flush are all registered. Each one therefore shows on `full`, `empty` and the issue outputs one clock edge after the cycle that carries it. The issue outputs are combinational from the stored entries, and an issuing slot empties at the following edge. The bench changes inputs on the falling edge and samples on the next falling edge. Each check therefore reads the state exactly one rising edge after its stimulus. Age order is checked one micro-op per cycle in consecutive cycles after a single wakeup makes several entries eligible.

// File: rtl/aiq_pkg.sv
package aiq_pkg;
  localparam int RS_ENTRIES = 8;

  typedef logic [RS_ENTRIES-1:0] slotVec_t;

  typedef struct packed {
    logic     flush;
    logic     allocEn;
    slotVec_t allocSel;
    logic     issueEn;
    slotVec_t issueSel;
  } rsStrobe_t;
endpackage

// File: rtl/aiq_store.sv
module aiq_store
  import aiq_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  rsStrobe_t        strobe,
  input  logic [TAG_W-1:0] allocDst,
  input  logic [TAG_W-1:0] allocSrc0,
  input  logic             allocSrc0Rdy,
  input  logic [TAG_W-1:0] allocSrc1,
  input  logic             allocSrc1Rdy,
  input  logic             wakeValid,
  input  logic [TAG_W-1:0] wakeTag,
  input  logic             earlyValid,
  input  logic [TAG_W-1:0] earlyTag,
  output slotVec_t         validVec,
  output slotVec_t         eligVec,
  output slotVec_t         olderMat [RS_ENTRIES],
  output logic [TAG_W-1:0] issueDst,
  output logic [TAG_W-1:0] issueSrc0,
  output logic [TAG_W-1:0] issueSrc1
);
  localparam int N = RS_ENTRIES;

  slotVec_t         validQ;
  slotVec_t         olderQ [N];
  logic [TAG_W-1:0] dstQ   [N];
  logic [TAG_W-1:0] src0Q  [N];
  logic [TAG_W-1:0] src1Q  [N];
  slotVec_t         rdy0Q, rdy1Q, next0Q, next1Q;
  slotVec_t         wake0, wake1, early0, early1;

  wire allocWake0  = wakeValid  && (wakeTag  == allocSrc0);
  wire allocWake1  = wakeValid  && (wakeTag  == allocSrc1);
  wire allocEarly0 = earlyValid && (earlyTag == allocSrc0);
  wire allocEarly1 = earlyValid && (earlyTag == allocSrc1);

  for (genvar e = 0; e < N; e++) begin : g_entry
    assign wake0[e]   = wakeValid  && (src0Q[e] == wakeTag);
    assign wake1[e]   = wakeValid  && (src1Q[e] == wakeTag);
    assign early0[e]  = earlyValid && (src0Q[e] == earlyTag);
    assign early1[e]  = earlyValid && (src1Q[e] == earlyTag);
    assign eligVec[e] = validQ[e] && (rdy0Q[e] || next0Q[e]) && (rdy1Q[e] || next1Q[e]);
    assign olderMat[e] = olderQ[e];
  end

  assign validVec = validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      rdy0Q  <= '0;
      rdy1Q  <= '0;
      next0Q <= '0;
      next1Q <= '0;
      for (int e = 0; e < N; e++) begin
        olderQ[e] <= '0;
        dstQ[e]   <= '0;
        src0Q[e]  <= '0;
        src1Q[e]  <= '0;
      end
    end else if (strobe.flush) begin
      validQ <= '0;
      for (int e = 0; e < N; e++) olderQ[e] <= '0;
    end else begin
      for (int e = 0; e < N; e++) begin
        if (strobe.allocEn && strobe.allocSel[e]) begin
          validQ[e] <= 1'b1;
          dstQ[e]   <= allocDst;
          src0Q[e]  <= allocSrc0;
          src1Q[e]  <= allocSrc1;
          rdy0Q[e]  <= allocSrc0Rdy || allocWake0;
          rdy1Q[e]  <= allocSrc1Rdy || allocWake1;
          next0Q[e] <= allocEarly0;
          next1Q[e] <= allocEarly1;
          olderQ[e] <= '0;
        end else if (strobe.issueEn && strobe.issueSel[e]) begin
          validQ[e] <= 1'b0;
          olderQ[e] <= '0;
        end else begin
          rdy0Q[e]  <= rdy0Q[e]  || wake0[e];
          rdy1Q[e]  <= rdy1Q[e]  || wake1[e];
          next0Q[e] <= next0Q[e] || early0[e];
          next1Q[e] <= next1Q[e] || early1[e];
          if (strobe.allocEn && validQ[e]) olderQ[e] <= olderQ[e] | strobe.allocSel;
        end
      end
    end
  end

  always_comb begin
    issueDst  = '0;
    issueSrc0 = '0;
    issueSrc1 = '0;
    for (int e = 0; e < N; e++) begin
      if (strobe.issueSel[e]) begin
        issueDst  = issueDst  | dstQ[e];
        issueSrc0 = issueSrc0 | src0Q[e];
        issueSrc1 = issueSrc1 | src1Q[e];
      end
    end
  end
endmodule

// File: rtl/aiq_pick.sv
module aiq_pick
  import aiq_pkg::*;
(
  input  logic      flush,
  input  logic      allocValid,
  input  slotVec_t  validVec,
  input  slotVec_t  eligVec,
  input  slotVec_t  olderMat [RS_ENTRIES],
  output rsStrobe_t strobe,
  output logic      full,
  output logic      empty
);
  localparam int N = RS_ENTRIES;

  slotVec_t freeSel;
  slotVec_t winVec;

  always_comb begin
    freeSel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeSel    = '0;
        freeSel[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_win
    slotVec_t beaten;
    always_comb begin
      for (int j = 0; j < N; j++) beaten[j] = eligVec[j] && olderMat[j][i];
    end
    assign winVec[i] = eligVec[i] && !(|beaten);
  end

  assign full  = &validVec;
  assign empty = ~|validVec;

  always_comb begin
    strobe.flush    = flush;
    strobe.allocEn  = allocValid && !full && !flush;
    strobe.allocSel = freeSel;
    strobe.issueEn  = (|winVec) && !flush;
    strobe.issueSel = winVec;
  end
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue
  import aiq_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             allocValid,
  input  logic [TAG_W-1:0] allocDst,
  input  logic [TAG_W-1:0] allocSrc0,
  input  logic             allocSrc0Rdy,
  input  logic [TAG_W-1:0] allocSrc1,
  input  logic             allocSrc1Rdy,
  input  logic             wakeValid,
  input  logic [TAG_W-1:0] wakeTag,
  input  logic             earlyValid,
  input  logic [TAG_W-1:0] earlyTag,
  output logic             full,
  output logic             empty,
  output logic             issueValid,
  output logic [TAG_W-1:0] issueDst,
  output logic [TAG_W-1:0] issueSrc0,
  output logic [TAG_W-1:0] issueSrc1
);
  rsStrobe_t strobe;
  slotVec_t  validVec;
  slotVec_t  eligVec;
  slotVec_t  olderMat [RS_ENTRIES];

  aiq_pick u_pick (
    .flush     (flush),
    .allocValid(allocValid),
    .validVec  (validVec),
    .eligVec   (eligVec),
    .olderMat  (olderMat),
    .strobe    (strobe),
    .full      (full),
    .empty     (empty)
  );

  aiq_store #(.TAG_W(TAG_W)) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .allocDst    (allocDst),
    .allocSrc0   (allocSrc0),
    .allocSrc0Rdy(allocSrc0Rdy),
    .allocSrc1   (allocSrc1),
    .allocSrc1Rdy(allocSrc1Rdy),
    .wakeValid   (wakeValid),
    .wakeTag     (wakeTag),
    .earlyValid  (earlyValid),
    .earlyTag    (earlyTag),
    .validVec    (validVec),
    .eligVec     (eligVec),
    .olderMat    (olderMat),
    .issueDst    (issueDst),
    .issueSrc0   (issueSrc0),
    .issueSrc1   (issueSrc1)
  );

  assign issueValid = strobe.issueEn;
endmodule

// File: rtl/aiq_checker.sv
module aiq_checker
  import aiq_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      flush,
  input logic      allocValid,
  input logic      allocSrc0Rdy,
  input logic      allocSrc1Rdy,
  input logic      full,
  input logic      empty,
  input logic      issueValid,
  input slotVec_t  validVec,
  input rsStrobe_t strobe
);
  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);

  // R2
  full_refuses_chk: assert property (@(posedge clk) disable iff (!rstN)
    full && allocValid && !issueValid && !flush |=> full);

  // R4
  single_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.issueSel));

  // R4
  issue_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !allocValid && !flush |=>
      $countones(validVec) == $countones($past(validVec)) - 1);

  // R1
  empty_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !issueValid);

  // R3
  ready_alloc_issues_chk: assert property (@(posedge clk) disable iff (!rstN)
    allocValid && !full && !flush && allocSrc0Rdy && allocSrc1Rdy |=> issueValid || flush);
endmodule

bind age_issue_queue aiq_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .flush       (flush),
  .allocValid  (allocValid),
  .allocSrc0Rdy(allocSrc0Rdy),
  .allocSrc1Rdy(allocSrc1Rdy),
  .full        (full),
  .empty       (empty),
  .issueValid  (issueValid),
  .validVec    (validVec),
  .strobe      (strobe)
);

// File: tb/age_issue_queue_tb.sv
module age_issue_queue_tb;
  localparam int TAG_W = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             flush = 1'b0;
  logic             allocValid = 1'b0;
  logic [TAG_W-1:0] allocDst = '0, allocSrc0 = '0, allocSrc1 = '0;
  logic             allocSrc0Rdy = 1'b0, allocSrc1Rdy = 1'b0;
  logic             wakeValid = 1'b0, earlyValid = 1'b0;
  logic [TAG_W-1:0] wakeTag = '0, earlyTag = '0;
  logic             full, empty, issueValid;
  logic [TAG_W-1:0] issueDst, issueSrc0, issueSrc1;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  age_issue_queue #(.TAG_W(TAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .allocValid(allocValid), .allocDst(allocDst),
    .allocSrc0(allocSrc0), .allocSrc0Rdy(allocSrc0Rdy),
    .allocSrc1(allocSrc1), .allocSrc1Rdy(allocSrc1Rdy),
    .wakeValid(wakeValid), .wakeTag(wakeTag),
    .earlyValid(earlyValid), .earlyTag(earlyTag),
    .full(full), .empty(empty), .issueValid(issueValid),
    .issueDst(issueDst), .issueSrc0(issueSrc0), .issueSrc1(issueSrc1)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    allocValid = 1'b0;
    wakeValid  = 1'b0;
    earlyValid = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic alloc(input int dst, input int s0, input bit r0, input int s1, input bit r1);
    allocValid   = 1'b1;
    allocDst     = TAG_W'(dst);
    allocSrc0    = TAG_W'(s0);
    allocSrc0Rdy = r0;
    allocSrc1    = TAG_W'(s1);
    allocSrc1Rdy = r1;
  endtask

  task automatic expectIssue(input string req, input int dst);
    check(req, int'(issueValid), 1);
    check(req, int'(issueDst), dst);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 issueValid", int'(issueValid), 0);

    // R3 R4 ready allocation issues with its tags, slot freed after
    alloc(5, 7, 1'b1, 9, 1'b1);
    tick(); quiet();
    expectIssue("R3 ready alloc", 5);
    check("R4 src0 tag", int'(issueSrc0), 7);
    check("R4 src1 tag", int'(issueSrc1), 9);
    check("R1 not empty", int'(empty), 0);
    tick();
    check("R4 freed", int'(empty), 1);
    check("R4 no reissue", int'(issueValid), 0);

    // R1 R2 fill eight waiting entries, then refuse a ninth
    for (int i = 0; i < 8; i++) begin
      alloc(10 + i, 48, 1'b0, i, 1'b1);
      tick();
    end
    quiet();
    check("R1 full", int'(full), 1);
    check("R3 none eligible", int'(issueValid), 0);
    alloc(60, 1, 1'b1, 2, 1'b1);
    tick(); quiet();
    check("R2 still full", int'(full), 1);
    check("R2 refused entry not issued", int'(issueValid), 0);

    // R5 R6 one wake makes all eligible; issue in allocation order
    wakeValid = 1'b1; wakeTag = 48;
    tick(); quiet();
    for (int i = 0; i < 8; i++) begin
      expectIssue("R5 age order", 10 + i);
      tick();
    end
    check("R2 refused entry absent", int'(empty), 1);

    // R5 younger entry in a lower slot issues after older ones
    alloc(20, 49, 1'b0, 0, 1'b1); tick();
    alloc(21, 50, 1'b0, 0, 1'b1); tick();
    alloc(22, 49, 1'b0, 0, 1'b1); tick();
    quiet(); wakeValid = 1'b1; wakeTag = 50;
    tick(); quiet();
    expectIssue("R6 wake single", 21);
    tick();
    check("R6 others wait", int'(issueValid), 0);
    alloc(23, 49, 1'b0, 0, 1'b1); tick();
    quiet(); wakeValid = 1'b1; wakeTag = 49;
    tick(); quiet();
    expectIssue("R5 oldest first", 20); tick();
    expectIssue("R5 second", 22); tick();
    expectIssue("R5 reused slot last", 23); tick();
    check("R5 drained", int'(empty), 1);

    // R6 sweep: eight wake orders, waiting on either source
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 8; i++) begin
        if (r % 2 == 0) alloc(i, 32 + i, 1'b0, 0, 1'b1);
        else            alloc(i, 0, 1'b1, 32 + i, 1'b0);
        tick();
      end
      quiet();
      for (int k = 0; k < 8; k++) begin
        int idx;
        idx = (k * 3 + r) % 8;
        wakeValid = 1'b1; wakeTag = TAG_W'(32 + idx);
        tick(); quiet();
        expectIssue("R6 sweep", idx);
        tick();
        check("R6 sweep idle", int'(issueValid), 0);
      end
      check("R6 sweep empty", int'(empty), 1);
    end

    // R7 early wakeup makes an entry eligible before its result
    alloc(40, 51, 1'b0, 0, 1'b1); tick(); quiet();
    earlyValid = 1'b1; earlyTag = 51;
    tick(); quiet();
    expectIssue("R7 early issue", 40);
    tick();
    check("R7 drained", int'(empty), 1);
    alloc(41, 52, 1'b0, 0, 1'b1); tick(); quiet();
    earlyValid = 1'b1; earlyTag = 53;
    tick(); quiet();
    check("R7 mismatch ignored", int'(issueValid), 0);

    // R8 same-cycle allocation and result wake
    alloc(50, 54, 1'b0, 0, 1'b1);
    wakeValid = 1'b1; wakeTag = 54;
    tick(); quiet();
    expectIssue("R8 alloc with wake", 50);
    tick();
    alloc(51, 0, 1'b1, 55, 1'b0);
    earlyValid = 1'b1; earlyTag = 55;
    tick(); quiet();
    expectIssue("R8 alloc with early", 51);
    tick();
    check("R8 entry 41 waits", int'(issueValid), 0);

    // R9 flush empties and drops a same-cycle allocation
    alloc(42, 56, 1'b0, 0, 1'b1); tick(); quiet();
    check("R9 occupied", int'(empty), 0);
    alloc(43, 0, 1'b1, 0, 1'b1);
    flush = 1'b1;
    tick(); quiet();
    check("R9 empty", int'(empty), 1);
    check("R9 no issue", int'(issueValid), 0);
    wakeValid = 1'b1; wakeTag = 52;
    tick();
    wakeTag = 56;
    tick(); quiet();
    check("R9 flushed stay gone", int'(issueValid), 0);
    check("R9 still empty", int'(empty), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule